// File: doc/BRIEF.md
# Filtered Single-Action Input Capture Channel

This block timestamps edges on an asynchronous input. The input first passes through a two-stage synchronizer and then a digital glitch filter. The filter's minimum accepted pulse width can be 0 (filter bypassed), 2, 4, 8 or 16 module-clock cycles. When the filtered level changes in a direction that the edge selection enables, the current value of a free-running 16-bit timebase is copied into a capture register. An event flag is set at the same time.

The timebase advances on ticks from one of two sources: every module clock, or an externally supplied global prescaler tick. A divider that software can set to any ratio from 1 to 16 sits between the tick source and the counter. When freezing is enabled, a debug-halt input stops both the divider and the counter.

Software reads the latest captured value at any time. It clears the event flag with a one-cycle write-one-to-clear pulse. A new capture always overwrites the older value.

Top module: `icap_channel`

## Requirements
- R1: Driving `rst_n` low forces `cap_val`, `cap_flag` and `cnt_val` to zero immediately, without waiting for a clock edge. Internal logic leaves reset on a clock edge after `rst_n` rises.
- R2: The `filt_sel` code sets the minimum pulse width W in module-clock cycles: 0 gives bypass (W=0), 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 7 give 16. A level on `evt_in` held for at least W cycles passes the filter. A shorter pulse is rejected and produces no capture.
- R3: With the filter bypassed, `cap_val` and `cap_flag` update on the 3rd rising clock edge after `evt_in` changes. With W of 2 or more, they update on edge W+2.
- R4: `edge_sel` bit 0 enables capture on a filtered rising edge, and bit 1 enables capture on a filtered falling edge. The value 2'b11 captures both edges. The value 2'b00 captures nothing and leaves `cap_val` and `cap_flag` unchanged.
- R5: `cap_val` receives the `cnt_val` value held just before the capture edge. Each new capture overwrites the previous value.
- R6: A capture sets `cap_flag`. A one-cycle `flag_clr` pulse clears `cap_flag` without changing `cap_val`. A capture in the same cycle as `flag_clr` leaves the flag set.
- R7: The counter advances by one every `div_sel`+1 source ticks and wraps from 16'hFFFF to 0.
- R8: When `src_sel` is 0, every module-clock cycle is a source tick. When `src_sel` is 1, only cycles with `gtick` high are source ticks.
- R9: While `freeze_en` and `dbg_halt` are both high, the counter and divider hold their values. `dbg_halt` alone has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | 1 | Asynchronous event input |
| filt_sel | input | 3 | Filter width code |
| edge_sel | input | 2 | Capture edge enables (bit0 rising, bit1 falling) |
| div_sel | input | 4 | Timebase divide ratio minus one |
| src_sel | input | 1 | Tick source: 0 module clock, 1 global tick |
| gtick | input | 1 | Global prescaler tick, one cycle wide |
| freeze_en | input | 1 | Allow debug halt to freeze the timebase |
| dbg_halt | input | 1 | Chip debug-halt indication |
| flag_clr | input | 1 | Write-one-to-clear pulse for the event flag |
| cap_val | output | 16 | Latest captured timebase value |
| cap_flag | output | 1 | Event flag |
| cnt_val | output | 16 | Current timebase value |

## Verification
Several properties are checked on every cycle. The filtered level only moves toward the synchronized input and never moves while the two agree. The counter only ever steps by one, and it holds while frozen or while no global tick arrives. No capture happens when both edge enables are off. A capture always leaves the flag set, and a clear with no capture always drops it. Only the bench scenarios can show the rest: the exact edge on which a capture lands for each filter width, which pulse lengths pass or are rejected at the width boundary, that the captured value matches the counter just before that edge, and the overall divide ratios and counter wrap.

// File: rtl/icap_pkg.sv
package icap_pkg;

  localparam int unsigned MAX_FILT = 16;
  localparam int unsigned FW_W     = $clog2(MAX_FILT + 1);

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;

  // filter width code to minimum pulse width in clocks
  function automatic logic [FW_W-1:0] filt_width(input logic [2:0] code);
    logic [FW_W-1:0] w;
    case (code)
      3'd0:    w = FW_W'(0);
      3'd1:    w = FW_W'(2);
      3'd2:    w = FW_W'(4);
      3'd3:    w = FW_W'(8);
      default: w = FW_W'(MAX_FILT);
    endcase
    return w;
  endfunction

endpackage

// File: rtl/icap_rst_sync.sv
module icap_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sn = sh_q[STAGES-1];

endmodule

// File: rtl/icap_in_filter.sv
module icap_in_filter #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned CW          = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          din,
  input  logic [CW-1:0] width,
  output logic          filt,
  output logic          upd
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   sync_lvl;
  logic                   filt_q, filt_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   done;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_comb sync_d = din;
    end else begin : g_syncn
      always_comb sync_d = {sync_q[SYNC_STAGES-2:0], din};
    end
  endgenerate

  assign sync_lvl = sync_q[SYNC_STAGES-1];

  always_comb begin
    done   = (width == '0) || (cnt_q == CW'(width - 1'b1));
    filt_d = filt_q;
    cnt_d  = '0;
    upd    = 1'b0;
    if (sync_lvl != filt_q) begin
      if (done) begin
        filt_d = sync_lvl;
        upd    = 1'b1;
      end else begin
        cnt_d  = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign filt = filt_q;

  AST_FILT_TOWARD_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(filt_q) |-> (filt_q == $past(sync_lvl))); // R2
  AST_FILT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl == filt_q) |=> $stable(filt_q)); // R2
  AST_BYPASS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ((width == '0) && (sync_lvl != filt_q)) |=> (filt_q != $past(filt_q))); // R3

endmodule

// File: rtl/icap_timebase.sv
module icap_timebase #(
  parameter int unsigned CW = 16,
  parameter int unsigned DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          src_sel,
  input  logic          gtick,
  input  logic [DW-1:0] div,
  input  logic          freeze_en,
  input  logic          dbg_halt,
  output logic [CW-1:0] cnt
);

  logic [DW-1:0] pre_q, pre_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          hold, tick, en;

  always_comb begin
    hold  = freeze_en & dbg_halt;
    tick  = src_sel ? gtick : 1'b1;
    en    = tick & ~hold;
    pre_d = pre_q;
    cnt_d = cnt_q;
    if (en) begin
      if (pre_q >= div) begin
        pre_d = '0;
        cnt_d = cnt_q + 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      cnt_q <= '0;
    end else begin
      pre_q <= pre_d;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cnt_q) |-> (cnt_q == CW'($past(cnt_q) + 1'b1))); // R7
  AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_en && dbg_halt) |=> ($stable(cnt_q) && $stable(pre_q))); // R9
  AST_GTICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel && !gtick) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/icap_capture.sv
module icap_capture #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          filt,
  input  logic          upd,
  input  logic [1:0]    edge_sel,
  input  logic [CW-1:0] tb,
  input  logic          clr,
  output logic [CW-1:0] cap,
  output logic          flag
);
  import icap_pkg::*;

  edge_mode_e    mode;
  logic          rise_ok, fall_ok, hit;
  logic [CW-1:0] cap_q, cap_d;
  logic          flag_q, flag_d;

  always_comb begin
    mode    = edge_mode_e'(edge_sel);
    rise_ok = (mode == EDGE_RISE) || (mode == EDGE_BOTH);
    fall_ok = (mode == EDGE_FALL) || (mode == EDGE_BOTH);
    hit     = upd & ((~filt & rise_ok) | (filt & fall_ok));
    cap_d   = hit ? tb : cap_q;
    if (hit)      flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    else          flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cap_q  <= cap_d;
      flag_q <= flag_d;
    end
  end

  assign cap  = cap_q;
  assign flag = flag_q;

  AST_CAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_q) |-> flag_q); // R6
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !flag_q); // R6
  AST_HIT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> flag_q); // R6
  AST_NONE_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_sel == 2'b00) |=> $stable(cap_q)); // R4

endmodule

// File: rtl/icap_channel.sv
module icap_channel #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned DIV_W       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_in,
  input  logic [2:0]       filt_sel,
  input  logic [1:0]       edge_sel,
  input  logic [DIV_W-1:0] div_sel,
  input  logic             src_sel,
  input  logic             gtick,
  input  logic             freeze_en,
  input  logic             dbg_halt,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] cap_val,
  output logic             cap_flag,
  output logic [CNT_W-1:0] cnt_val
);
  import icap_pkg::*;

  localparam int unsigned FCW = FW_W;

  logic           rst_sn;
  logic [FCW-1:0] width;
  logic           filt, upd;
  logic [CNT_W-1:0] tb;

  assign width = filt_width(filt_sel);

  icap_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sn(rst_sn)
  );

  icap_in_filter #(.SYNC_STAGES(SYNC_STAGES), .CW(FCW)) u_filt (
    .clk(clk), .rst_n(rst_sn), .din(evt_in), .width(width),
    .filt(filt), .upd(upd)
  );

  icap_timebase #(.CW(CNT_W), .DW(DIV_W)) u_tb (
    .clk(clk), .rst_n(rst_sn), .src_sel(src_sel), .gtick(gtick),
    .div(div_sel), .freeze_en(freeze_en), .dbg_halt(dbg_halt), .cnt(tb)
  );

  icap_capture #(.CW(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_sn), .filt(filt), .upd(upd), .edge_sel(edge_sel),
    .tb(tb), .clr(flag_clr), .cap(cap_val), .flag(cap_flag)
  );

  assign cnt_val = tb;

endmodule

// File: tb/test_icap_channel.sv
module test_icap_channel;

  localparam int CLK_PER = 10;
  localparam int WD_CYC  = 150000;
  localparam int NV      = 12;

  // {filt_sel[3], edge_sel[2], div_sel[4], src_sel[1], len[5]}
  localparam logic [14:0] VEC [NV] = '{
    {3'd0, 2'b01, 4'd0,  1'b0, 5'd1},
    {3'd0, 2'b10, 4'd0,  1'b0, 5'd3},
    {3'd1, 2'b01, 4'd0,  1'b0, 5'd1},
    {3'd1, 2'b01, 4'd0,  1'b0, 5'd2},
    {3'd2, 2'b11, 4'd2,  1'b0, 5'd3},
    {3'd2, 2'b11, 4'd2,  1'b0, 5'd4},
    {3'd3, 2'b01, 4'd0,  1'b1, 5'd7},
    {3'd3, 2'b11, 4'd5,  1'b0, 5'd8},
    {3'd4, 2'b10, 4'd0,  1'b0, 5'd15},
    {3'd4, 2'b11, 4'd15, 1'b0, 5'd16},
    {3'd0, 2'b00, 4'd0,  1'b0, 5'd5},
    {3'd7, 2'b01, 4'd1,  1'b1, 5'd20}
  };

  logic clk, rst_n, evt_in, src_sel, gtick, freeze_en, dbg_halt, flag_clr;
  logic [2:0] filt_sel;
  logic [1:0] edge_sel;
  logic [3:0] div_sel;
  logic [15:0] cap_val, cnt_val;
  logic cap_flag;

  int n_cmp = 0;
  int n_mis = 0;
  logic [15:0] hist [64];
  logic [15:0] exp_cap;

  icap_channel i_icap_channel (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .filt_sel(filt_sel),
    .edge_sel(edge_sel), .div_sel(div_sel), .src_sel(src_sel), .gtick(gtick),
    .freeze_en(freeze_en), .dbg_halt(dbg_halt), .flag_clr(flag_clr),
    .cap_val(cap_val), .cap_flag(cap_flag), .cnt_val(cnt_val)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PER/2) clk = ~clk;
  end

  initial begin
    int ph;
    ph = 0;
    gtick = 1'b0;
    forever begin
      @(negedge clk);
      ph = (ph == 2) ? 0 : ph + 1;
      gtick = (ph == 0);
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_mis++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] c);
    case (c)
      3'd0: return 0;
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 16;
    endcase
  endfunction

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_mis++;
    $display("FAIL watchdog: actual expired expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    rst_n = 1'b0; evt_in = 1'b0; filt_sel = 3'd0; edge_sel = 2'b01;
    div_sel = 4'd0; src_sel = 1'b0; freeze_en = 1'b0; dbg_halt = 1'b0;
    flag_clr = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "cap_val in reset", 32'(cap_val), 32'd0);
    chk("R1", "cap_flag in reset", 32'(cap_flag), 32'd0);
    chk("R1", "cnt_val in reset", 32'(cnt_val), 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // vector table walk
    for (int v = 0; v < NV; v++) begin
      logic [14:0] e;
      int w, lat, len;
      logic pass, exp_r, exp_f;
      string tag;
      e = VEC[v];
      filt_sel = e[14:12]; edge_sel = e[11:10]; div_sel = e[9:6];
      src_sel = e[5]; len = int'(e[4:0]);
      w = width_of(filt_sel);
      lat = (w == 0) ? 3 : w + 2;
      pass = (len >= w);
      exp_r = pass && edge_sel[0];
      exp_f = pass && edge_sel[1];
      tag = (edge_sel == 2'b00) ? "R4" : (pass ? "R5" : "R2");
      repeat (25) @(negedge clk);
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
      @(negedge clk);
      chk("R6", "flag after clear", 32'(cap_flag), 32'd0);
      for (int i = 0; i < len + lat + 3; i++) begin
        hist[i] = cnt_val;
        if (exp_r && i == lat - 1)
          chk("R3", "flag before capture edge", 32'(cap_flag), 32'd0);
        if (exp_r && i == lat) begin
          chk("R3", "cap_val on capture edge", 32'(cap_val), 32'(hist[lat-1]));
          chk("R3", "flag on capture edge", 32'(cap_flag), 32'd1);
        end
        evt_in = (i < len);
        @(negedge clk);
      end
      if (exp_f)      exp_cap = hist[len+lat-1];
      else if (exp_r) exp_cap = hist[lat-1];
      else            exp_cap = cap_val === 16'hxxxx ? 16'd0 : exp_cap;
      if (v == 0 && !(exp_r || exp_f)) exp_cap = 16'd0;
      chk(tag, "cap_val after pulse", 32'(cap_val), 32'(exp_cap));
      chk(tag, "flag after pulse", 32'(cap_flag), 32'(exp_r || exp_f));
    end

    // R6: capture wins over a same-cycle clear; clear keeps cap_val
    filt_sel = 3'd0; edge_sel = 2'b01; div_sel = 4'd0; src_sel = 1'b0;
    repeat (5) @(negedge clk);
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0; @(negedge clk);
    evt_in = 1'b1;
    repeat (2) @(negedge clk);
    flag_clr = 1'b1;
    @(negedge clk);
    flag_clr = 1'b0;
    chk("R6", "flag with capture and clear together", 32'(cap_flag), 32'd1);
    exp_cap = cap_val;
    flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
    chk("R6", "flag after lone clear", 32'(cap_flag), 32'd0);
    chk("R6", "cap_val kept by clear", 32'(cap_val), 32'(exp_cap));
    evt_in = 1'b0;
    repeat (5) @(negedge clk);

    // R7: divide by 4
    begin
      logic [15:0] a;
      div_sel = 4'd3; src_sel = 1'b0;
      repeat (6) @(negedge clk);
      a = cnt_val;
      repeat (40) @(negedge clk);
      chk("R7", "divide by 4 over 40 clocks", 32'(cnt_val - a), 32'd10);
    end

    // R8: global tick source
    begin
      logic [15:0] a;
      div_sel = 4'd0; src_sel = 1'b1;
      repeat (6) @(negedge clk);
      a = cnt_val;
      repeat (30) @(negedge clk);
      chk("R8", "global tick every 3 clocks", 32'(cnt_val - a), 32'd10);
      src_sel = 1'b0;
      @(negedge clk);
    end

    // R9: freeze
    begin
      logic [15:0] a;
      freeze_en = 1'b1; dbg_halt = 1'b1;
      @(negedge clk);
      a = cnt_val;
      repeat (10) @(negedge clk);
      chk("R9", "frozen counter", 32'(cnt_val), 32'(a));
      freeze_en = 1'b0;
      @(negedge clk);
      a = cnt_val;
      repeat (10) @(negedge clk);
      chk("R9", "halt without freeze enable", 32'(cnt_val - a), 32'd10);
      dbg_halt = 1'b0;
    end

    // R7: wrap
    begin
      int guard;
      guard = 0;
      while (cnt_val != 16'hFFFF && guard < 70000) begin
        @(negedge clk);
        guard++;
      end
      @(negedge clk);
      chk("R7", "wrap to zero", 32'(cnt_val), 32'd0);
    end

    // R1: reset asserts without a clock edge
    #(CLK_PER/4);
    rst_n = 1'b0;
    #1;
    chk("R1", "async reset cap_val", 32'(cap_val), 32'd0);
    chk("R1", "async reset cnt_val", 32'(cnt_val), 32'd0);
    chk("R1", "async reset cap_flag", 32'(cap_flag), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

endmodule